// File: doc/BRIEF.md
# Even-Spacing Pulse Rate Reducer

This block thins a stream of single-cycle input pulses down to a chosen fraction of its rate. A rate word R of width W sets that fraction: out of every 2^W input pulses, exactly R are passed and the rest are deleted. The block never creates a pulse. It only deletes them. The deleted pulses are spread as evenly as possible, so any two runs of consecutive deletions differ in length by one at most. The output can serve as a clock enable for slower logic. It can also drive an external RC integrator as a one-bit DAC, whose spectrum sits higher than a PWM stream of the same resolution.

Internally, a W-bit phase counter counts input pulses and marks the start of each period of 2^W pulses. A W-bit accumulator adds the active rate on every input pulse, and the carry out of that addition decides whether the pulse is passed. The rate word is taken only on the first pulse of each period, so changing it mid-period never breaks the spacing pattern. Each output pulse appears one clock after the input pulse it comes from.

Top module: `rate_thinner`

## Requirements
- R1: The output pulse is high in a cycle only if the input pulse was high in the previous cycle. The output is the registered, gated input.
- R2: When the active rate is 0, every input pulse is deleted.
- R3: When the active rate is 2^W-1, the first pulse of each period is deleted and the other 2^W-1 pulses pass.
- R4: Over each period of 2^W input pulses counted from reset, exactly R pulses are passed, where R is the active rate of that period.
- R5: Number the input pulses of a period k = 0 .. 2^W-1. Pulse k is passed exactly when floor((k+1)·R/2^W) > floor(k·R/2^W).
- R6: With a constant nonzero rate, the lengths of all runs of consecutive deleted pulses within a period differ by at most one.
- R7: The rate input is sampled only on pulse k = 0 of each period. A change at any other time has no effect until the next period starts.
- R8: Cycles with the input pulse low do not advance the pattern and produce no output pulse.
- R9: While reset is asserted the output is low. After reset the next input pulse is pulse k = 0 of a new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pulse_i | input | 1 | Input pulse, one per cycle when high |
| rate_i | input | RATE_W | Rate word: number of pulses passed per 2^RATE_W input pulses |
| pulse_o | output | 1 | Thinned output pulse, one cycle after the input pulse it comes from |

## Verification
Some properties are checked on every cycle by the assertions: an output pulse never appears without an input pulse one cycle earlier, a zero rate blocks every pulse, the maximum rate passes every pulse except the first of a period, the accumulator is empty at each period boundary, and the latched rate moves only on a period's first pulse. Other behaviour shows only across many pulses, so only the bench scenarios can reveal it. These are the exact count per period, the pulse-by-pulse placement of passed pulses, the limit on run lengths, and the period-aligned sampling of a rate that changes mid-period. The bench checks these by sweeping every rate word of a 4-bit configuration, with both back-to-back and gapped input pulses.

// File: rtl/rate_thinner_pkg.sv
package rate_thinner_pkg;
  typedef enum logic {
    GATE_DROP = 1'b0,
    GATE_PASS = 1'b1
  } gate_e;
endpackage

// File: rtl/rt_rate_latch.sv
module rt_rate_latch #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [RATE_W-1:0] phase_o,
  output logic [RATE_W-1:0] rate_eff_o
);
  logic [RATE_W-1:0] phase_q, phase_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              at_start;
  logic              phase_en, rate_en;

  assign at_start = (phase_q == '0);
  assign phase_en = pulse_i;
  assign rate_en  = pulse_i && at_start;

  always_comb begin
    phase_d = phase_q + 1'b1;
    rate_d  = rate_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      rate_q  <= '0;
    end else begin
      if (phase_en) phase_q <= phase_d;
      if (rate_en)  rate_q  <= rate_d;
    end
  end

  assign phase_o    = phase_q;
  assign rate_eff_o = at_start ? rate_i : rate_q;

  AST_RATE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pulse_i && phase_q == '0) |=> $stable(rate_q)); // R7
endmodule

// File: rtl/rt_accum.sv
module rt_accum #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic [RATE_W-1:0] rate_eff_i,
  input  logic [RATE_W-1:0] phase_i,
  output logic              carry_o
);
  localparam int SUM_W = RATE_W + 1;

  logic [RATE_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, rate_eff_i};
    acc_d = sum[RATE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (pulse_i) acc_q <= acc_d;
  end

  assign carry_o = sum[RATE_W];

  AST_EMPTY_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == '0) |-> (acc_q == '0)); // R4
endmodule

// File: rtl/rt_gate.sv
module rt_gate
  import rate_thinner_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic carry_i,
  output logic pulse_o
);
  gate_e sel;
  logic  out_d, out_q;

  always_comb begin
    sel   = (pulse_i && carry_i) ? GATE_PASS : GATE_DROP;
    out_d = (sel == GATE_PASS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign pulse_o = out_q;
endmodule

// File: rtl/rate_thinner.sv
module rate_thinner #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              pulse_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [RATE_W-1:0] phase;
  logic [RATE_W-1:0] rate_eff;
  logic              carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rt_rate_latch #(.RATE_W(RATE_W)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .pulse_i    (pulse_i),
    .rate_i     (rate_i),
    .phase_o    (phase),
    .rate_eff_o (rate_eff)
  );

  rt_accum #(.RATE_W(RATE_W)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .pulse_i    (pulse_i),
    .rate_eff_i (rate_eff),
    .phase_i    (phase),
    .carry_o    (carry)
  );

  rt_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .pulse_i (pulse_i),
    .carry_i (carry),
    .pulse_o (pulse_o)
  );

  AST_NO_NEW_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    pulse_o |-> $past(pulse_i)); // R1
  AST_ZERO_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (pulse_i && rate_eff == '0) |=> !pulse_o); // R2
  AST_FULL_PASSES: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (pulse_i && rate_eff == '1 && phase != '0) |=> pulse_o); // R3
  AST_FULL_DROPS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (pulse_i && rate_eff == '1 && phase == '0) |=> !pulse_o); // R3
endmodule

// File: tb/tb_rate_thinner.sv
module tb_rate_thinner;
  localparam int W   = 4;
  localparam int PER = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pulse_i;
  logic [W-1:0] rate_i;
  logic         pulse_o;

  int checks = 0;
  int fails  = 0;
  int k = 0, rq = 0, passes = 0;
  int cur_run = 0, run_min = 1000, run_max = 0;

  always #2.5 clk = ~clk;

  rate_thinner #(.RATE_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse_i), .rate_i(rate_i), .pulse_o(pulse_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (k=%0d rate=%0d)", tag, act, exp, k, rq);
    end
  endtask

  task automatic step(input bit v, input int r);
    bit    exp;
    string tag;
    pulse_i = v;
    rate_i  = r[W-1:0];
    if (v) begin
      if (k == 0) rq = r;
      exp = (((k + 1) * rq) / PER) != ((k * rq) / PER);
      if (rq == 0)            tag = "R2";
      else if (rq == PER - 1) tag = "R3";
      else                    tag = "R5";
    end else begin
      exp = 1'b0;
      tag = "R1/R8";
    end
    @(posedge clk);
    @(negedge clk);
    check(pulse_o == exp, tag, int'(pulse_o), int'(exp));
    if (v) begin
      if (exp) begin
        passes++;
        if (cur_run > 0) begin
          if (cur_run < run_min) run_min = cur_run;
          if (cur_run > run_max) run_max = cur_run;
        end
        cur_run = 0;
      end else begin
        cur_run++;
      end
      k = (k + 1) % PER;
      if (k == 0) begin
        check(passes == rq, "R4", passes, rq);
        if (rq > 0 && run_max > 0)
          check(run_max - run_min <= 1, "R6", run_max - run_min, 1);
        passes = 0; cur_run = 0; run_min = 1000; run_max = 0;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pulse_i = 1'b0;
    repeat (3) @(negedge clk);
    check(pulse_o == 1'b0, "R9", int'(pulse_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    k = 0; passes = 0; cur_run = 0; run_min = 1000; run_max = 0;
    check(pulse_o == 1'b0, "R9", int'(pulse_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rate_i = '0;
    do_reset();

    // Sweep every rate: back-to-back pulses for even rates, gapped for odd (R5, R6, R8)
    for (int r = 0; r < PER; r++) begin
      for (int i = 0; i < 2 * PER; i++) begin
        if (r % 2 == 1 && i % 3 == 1) step(1'b0, r);
        step(1'b1, r);
      end
    end

    // R7: rate changed mid-period is ignored until the next period
    for (int i = 0; i < PER; i++) step(1'b1, (i < 3) ? 5 : 11);
    for (int i = 0; i < PER; i++) step(1'b1, (i == 0) ? 11 : 2);

    // R9: reset in the middle of a period restarts at pulse k = 0
    for (int i = 0; i < 5; i++) step(1'b1, 7);
    do_reset();
    for (int i = 0; i < PER; i++) step(1'b1, 9);
    for (int i = 0; i < 4; i++) step(1'b0, 9);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule